// File: doc/BRIEF.md
# Memory Area Decoder and Wait Controller

This block sits between a CPU-side request port and an external memory bus. For each request it picks a memory area from a field of the physical address. It then asserts that area's chip select together with a read or a write strobe. The strobe is held for a wait count programmed for that area. Areas 5 and 6 accept a longer count than the others. After the programmed cycles the strobe is held further for as long as an external wait input stays high.

Two kinds of back-to-back access can cause a data bus conflict on the shared memory bus: a move to a different area, and a write that follows a read of the same area. For either kind the controller inserts one idle cycle before the chip select of the new access. Requests whose area field names no external area, or whose address lies above the decoded space, are answered at once with an error and cause no bus activity. The data width of area 0 comes from a strap input. The width of every other area comes from a configuration field.

Top module: `area_wait_ctl`

## Requirements
- R1: The area number is address bits [28:26]. An access to area k asserts `cs_o[k]` (bit position equals area number), with `rd_o` for a read (`req_write`=0) or `wr_o` for a write. At most one chip select is high, and `mem_addr_o` holds address bits [25:0] while it is high.
- R2: A request whose area field is 1 or 7, or whose address bits [31:29] are not all zero, is answered with `rsp_valid` and `rsp_err` both high in the first cycle after acceptance. It asserts no chip select and no strobe, and it does not change the area history used by R6 and R7.
- R3: With `ext_wait` low, chip select and strobe stay high for exactly W cycles. W is the clamped value of field k of `cfg_wait`, which occupies bits [6k+5:6k]. In the cycle after the last of them the strobe is low and `rsp_valid` is high for one cycle with `rsp_err` low.
- R4: A programmed value of 0 is used as 1. Areas 0, 2, 3 and 4 are limited to 10 cycles, and areas 5 and 6 are limited to 38.
- R5: `ext_wait` is sampled first at the end of the W-th strobe cycle. While it is high at a cycle end, the strobe is held one more cycle, and the strobe ends in the cycle after it is seen low. Its level during the earlier programmed cycles has no effect.
- R6: When an accepted access targets a different area from the previous non-error access, exactly one cycle with no chip select passes between acceptance and the chip select.
- R7: Within the same area, exactly one idle cycle is inserted when a write follows a read. No idle cycle is inserted for read after read, read after write, or write after write.
- R8: `width_o` shows `strap_w0` for area 0, and field k of `cfg_width` (bits [2k+1:2k]) for any other area k. It is held for the whole access.
- R9: `req_ready` is high only when the controller is idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge.
- R10: After reset no chip select or strobe is active, `req_ready` is high and `rsp_valid` is low. The first access after reset gets no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 32 | Physical byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion is an error (undecodable address) |
| cfg_wait | input | 48 | Per-area wait counts, 6 bits per area |
| cfg_width | input | 16 | Per-area width codes, 2 bits per area |
| strap_w0 | input | 2 | Width code of area 0 |
| ext_wait | input | 1 | External wait, extends the strobe while high |
| cs_o | output | 8 | Per-area chip selects, active high |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| width_o | output | 2 | Width code of the current area |
| mem_addr_o | output | 26 | Offset within the area |

## Verification
The idle-cycle insertion and the end of an access can meet in one cycle. A request arriving in the same cycle as the previous completion pulse is decided against a history that was updated only at acceptance. The bench issues every request on the completion cycle of the one before, so that each request is back to back with the previous access. It runs area changes, write-after-read pairs and error requests in between, and it judges each access by counting, at the ports, the idle cycles before the chip select and the strobe cycles after it. A second meeting point is the last programmed wait cycle, where `ext_wait` is first sampled. The bench drives `ext_wait` high during the early programmed cycles and expects no stretch from that.

// File: rtl/awc_pkg.sv
package awc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_ACC  = 2'd2,
    ST_HOLD = 2'd3
  } awc_state_e;
endpackage

// File: rtl/awc_area_decode.sv
module awc_area_decode #(
  parameter int AREA_W     = 3,
  parameter int WAIT_W     = 6,
  parameter int WID_W      = 2,
  parameter int SHORT_MAX  = 10,
  parameter int LONG_MAX   = 38,
  parameter logic [(1<<AREA_W)-1:0] LONG_MASK  = 8'b0110_0000,
  parameter logic [(1<<AREA_W)-1:0] VALID_MASK = 8'b0111_1101,
  localparam int N_AREA = 1 << AREA_W
) (
  input  logic [AREA_W-1:0]        area_i,
  input  logic                     high_bits_set,
  input  logic [N_AREA*WAIT_W-1:0] cfg_wait,
  input  logic [N_AREA*WID_W-1:0]  cfg_width,
  input  logic [WID_W-1:0]         strap_w0,
  output logic                     bad_o,
  output logic [WAIT_W-1:0]        wait_o,
  output logic [WID_W-1:0]         width_o
);
  logic [WAIT_W-1:0] clamped [N_AREA];

  for (genvar i = 0; i < N_AREA; i++) begin : g_clamp
    localparam int MAXV = LONG_MASK[i] ? LONG_MAX : SHORT_MAX;
    logic [WAIT_W-1:0] raw;
    assign raw = cfg_wait[i*WAIT_W +: WAIT_W];
    always_comb begin
      if (raw == '0)                        clamped[i] = WAIT_W'(1);
      else if (int'(raw) > MAXV)            clamped[i] = WAIT_W'(MAXV);
      else                                  clamped[i] = raw;
    end
  end

  assign bad_o   = high_bits_set || !VALID_MASK[area_i];
  assign wait_o  = clamped[area_i];
  assign width_o = (area_i == '0) ? strap_w0 : cfg_width[area_i*WID_W +: WID_W];
endmodule

// File: rtl/awc_wait_counter.sv
module awc_wait_counter #(
  parameter int WAIT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              dec,
  output logic              last
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - WAIT_W'(1);
  end

  assign last = (cnt == WAIT_W'(1));
endmodule

// File: rtl/awc_gap_detect.sv
module awc_gap_detect #(
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [AREA_W-1:0] area_i,
  input  logic              write_i,
  output logic              need_gap
);
  logic              have_prev;
  logic [AREA_W-1:0] prev_area;
  logic              prev_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev  <= 1'b0;
      prev_area  <= '0;
      prev_write <= 1'b0;
    end else if (upd) begin
      have_prev  <= 1'b1;
      prev_area  <= area_i;
      prev_write <= write_i;
    end
  end

  assign need_gap = have_prev &&
                    ((prev_area != area_i) || (write_i && !prev_write));
endmodule

// File: rtl/area_wait_ctl.sv
module area_wait_ctl
  import awc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int AREA_LSB  = 26,
  parameter int AREA_W    = 3,
  parameter int WAIT_W    = 6,
  parameter int WID_W     = 2,
  parameter int SHORT_MAX = 10,
  parameter int LONG_MAX  = 38,
  localparam int N_AREA   = 1 << AREA_W,
  localparam int TOP_LSB  = AREA_LSB + AREA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  output logic                     rsp_valid,
  output logic                     rsp_err,
  input  logic [N_AREA*WAIT_W-1:0] cfg_wait,
  input  logic [N_AREA*WID_W-1:0]  cfg_width,
  input  logic [WID_W-1:0]         strap_w0,
  input  logic                     ext_wait,
  output logic [N_AREA-1:0]        cs_o,
  output logic                     rd_o,
  output logic                     wr_o,
  output logic [WID_W-1:0]         width_o,
  output logic [AREA_LSB-1:0]      mem_addr_o
);
  awc_state_e state, nxt;

  logic [AREA_W-1:0] d_area, acc_area, nxt_area;
  logic              d_bad, need_gap, cnt_last;
  logic [WAIT_W-1:0] d_wait;
  logic [WID_W-1:0]  d_width;
  logic              acc_wr, nxt_wr;
  logic              accept, go, fin, strobe_on;

  assign d_area = req_addr[AREA_LSB +: AREA_W];

  awc_area_decode #(
    .AREA_W(AREA_W), .WAIT_W(WAIT_W), .WID_W(WID_W),
    .SHORT_MAX(SHORT_MAX), .LONG_MAX(LONG_MAX)
  ) u_dec (
    .area_i       (d_area),
    .high_bits_set(|req_addr[ADDR_W-1:TOP_LSB]),
    .cfg_wait     (cfg_wait),
    .cfg_width    (cfg_width),
    .strap_w0     (strap_w0),
    .bad_o        (d_bad),
    .wait_o       (d_wait),
    .width_o      (d_width)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign go        = accept && !d_bad;

  awc_gap_detect #(.AREA_W(AREA_W)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .upd     (go),
    .area_i  (d_area),
    .write_i (req_write),
    .need_gap(need_gap)
  );

  awc_wait_counter #(.WAIT_W(WAIT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (go),
    .load_val(d_wait),
    .dec     (state == ST_ACC),
    .last    (cnt_last)
  );

  always_comb begin
    nxt = state;
    fin = 1'b0;
    unique case (state)
      ST_IDLE: if (go) nxt = need_gap ? ST_GAP : ST_ACC;
      ST_GAP:  nxt = ST_ACC;
      ST_ACC:  if (cnt_last) begin
                 if (ext_wait) nxt = ST_HOLD;
                 else begin nxt = ST_IDLE; fin = 1'b1; end
               end
      ST_HOLD: if (!ext_wait) begin nxt = ST_IDLE; fin = 1'b1; end
      default: nxt = ST_IDLE;
    endcase
  end

  assign nxt_area  = go ? d_area : acc_area;
  assign nxt_wr    = go ? req_write : acc_wr;
  assign strobe_on = (nxt == ST_ACC) || (nxt == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      acc_area   <= '0;
      acc_wr     <= 1'b0;
      width_o    <= '0;
      mem_addr_o <= '0;
      cs_o       <= '0;
      rd_o       <= 1'b0;
      wr_o       <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
    end else begin
      state <= nxt;
      if (go) begin
        acc_area   <= d_area;
        acc_wr     <= req_write;
        width_o    <= d_width;
        mem_addr_o <= req_addr[AREA_LSB-1:0];
      end
      cs_o      <= strobe_on ? (N_AREA'(1) << nxt_area) : '0;
      rd_o      <= strobe_on && !nxt_wr;
      wr_o      <= strobe_on && nxt_wr;
      rsp_valid <= fin || (accept && d_bad);
      rsp_err   <= accept && d_bad;
    end
  end
endmodule

// File: rtl/area_wait_chk.sv
module area_wait_chk #(
  parameter int N_AREA = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [N_AREA-1:0] cs_o,
  input logic              rd_o,
  input logic              wr_o,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              ext_wait
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(cs_o)); // R1
  AST_STROBE_MATCH: assert property (@(posedge clk) disable iff (rst) ((rd_o || wr_o) == (|cs_o)) && !(rd_o && wr_o)); // R1
  AST_NO_BAD_CS: assert property (@(posedge clk) disable iff (rst) !cs_o[1] && !cs_o[N_AREA-1]); // R2
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst) rsp_err |-> (cs_o == '0) && rsp_valid); // R2
  AST_END_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst) (rsp_valid && !rsp_err) |-> !rd_o && !wr_o && $past(rd_o || wr_o)); // R3
  AST_END_WAIT_LOW: assert property (@(posedge clk) disable iff (rst) (rsp_valid && !rsp_err) |-> !$past(ext_wait)); // R5
  AST_CS_STABLE: assert property (@(posedge clk) disable iff (rst) ((|cs_o) && $past(|cs_o)) |-> $stable(cs_o)); // R1
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst) req_ready |-> (cs_o == '0)); // R9
endmodule

bind area_wait_ctl area_wait_chk #(.N_AREA(1 << AREA_W)) u_chk (
  .clk(clk), .rst(rst), .cs_o(cs_o), .rd_o(rd_o), .wr_o(wr_o),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .ext_wait(ext_wait)
);

// File: tb/area_wait_ctl_bench.sv
module area_wait_ctl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_err;
  logic [47:0] cfg_wait = '0;
  logic [15:0] cfg_width = '0;
  logic [1:0]  strap_w0 = 2'd2;
  logic        ext_wait = 1'b0;
  logic [7:0]  cs_o;
  logic        rd_o, wr_o;
  logic [1:0]  width_o;
  logic [25:0] mem_addr_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit have_prev = 0;
  int prev_area = 0;
  bit prev_wr = 0;

  always #10 clk = ~clk;

  area_wait_ctl u_area_wait_ctl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .cfg_wait(cfg_wait), .cfg_width(cfg_width),
    .strap_w0(strap_w0), .ext_wait(ext_wait), .cs_o(cs_o), .rd_o(rd_o),
    .wr_o(wr_o), .width_o(width_o), .mem_addr_o(mem_addr_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_wait(input int area);
    int raw = int'(cfg_wait[area*6 +: 6]);
    int mx = (area == 5 || area == 6) ? 38 : 10;
    if (raw == 0) return 1;
    if (raw > mx) return mx;
    return raw;
  endfunction

  function automatic [31:0] mk_addr(input int area, input int off);
    return {3'b000, 3'(area), 26'(off)};
  endfunction

  // One good access; hold = extra cycles of ext_wait, early = ext_wait high in programmed cycles
  task automatic run_access(input int area, input int off, input bit wr,
                            input int hold, input bit early);
    int w = exp_wait(area);
    int egap = (have_prev && (area != prev_area || (wr && !prev_wr))) ? 1 : 0;
    int ewid = (area == 0) ? int'(strap_w0) : int'(cfg_width[area*2 +: 2]);
    int gap = 0, sc = 0;
    bit got = 0, csok = 1, stok = 1, widok = 1, adok = 1, errseen = 0, rdy_ok = 1;
    chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    req_addr = mk_addr(area, off);
    req_write = wr;
    req_valid = 1'b1;
    ext_wait = early;
    @(posedge clk);
    for (int c = 0; c < 200 && !got; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (rsp_valid) begin
        got = 1;
        errseen = rsp_err;
        chk(!rd_o && !wr_o && cs_o == 0, "R3 strobe low at completion", cs_o, 0);
      end else begin
        if (req_ready) rdy_ok = 0;
        if (cs_o != 0) begin
          sc++;
          if (cs_o != (8'd1 << area)) csok = 0;
          if (rd_o != !wr || wr_o != wr) stok = 0;
          if (int'(width_o) != ewid) widok = 0;
          if (int'(mem_addr_o) != off) adok = 0;
          ext_wait = (sc < w) ? early : (sc < w + hold);
        end else begin
          if (sc == 0) gap++;
          ext_wait = 1'b0;
        end
      end
    end
    ext_wait = 1'b0;
    chk(got && !errseen, "R3 completion without error", errseen, 0);
    chk(rdy_ok, "R9 ready low while busy", rdy_ok, 1);
    chk(gap == egap, "R6/R7 idle cycles before chip select", gap, egap);
    chk(sc == w + hold, "R3/R4/R5 strobe length", sc, w + hold);
    chk(csok, "R1 chip select matches area", area, area);
    chk(stok, "R1 strobe direction", wr, wr);
    chk(widok, "R8 width held", ewid, ewid);
    chk(adok, "R1 offset output", off, off);
    have_prev = 1;
    prev_area = area;
    prev_wr = wr;
  endtask

  task automatic run_bad(input logic [31:0] addr);
    bit csseen = 0;
    chk(req_ready == 1'b1, "R9 ready before bad request", req_ready, 1);
    req_addr = addr;
    req_write = 1'b0;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_err, "R2 error response next cycle", {rsp_valid, rsp_err}, 3);
    if (cs_o != 0 || rd_o || wr_o) csseen = 1;
    @(negedge clk);
    if (cs_o != 0 || rd_o || wr_o) csseen = 1;
    chk(!csseen, "R2 no chip select on error", csseen, 0);
    chk(!rsp_valid, "R2 single error pulse", rsp_valid, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // wait fields: a0=3 a2=4 a3=0 a4=63 a5=63 a6=20
    cfg_wait[0*6 +: 6] = 6'd3;
    cfg_wait[1*6 +: 6] = 6'd5;
    cfg_wait[2*6 +: 6] = 6'd4;
    cfg_wait[3*6 +: 6] = 6'd0;
    cfg_wait[4*6 +: 6] = 6'd63;
    cfg_wait[5*6 +: 6] = 6'd63;
    cfg_wait[6*6 +: 6] = 6'd20;
    cfg_wait[7*6 +: 6] = 6'd5;
    cfg_width = 16'b01_10_00_11_10_01_11_00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(cs_o == 0 && !rd_o && !wr_o, "R10 no strobe after reset", cs_o, 0);
    chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R10 no response after reset", rsp_valid, 0);
    // R10 first access: no gap; R8 strap width for area 0
    run_access(0, 'h123, 0, 0, 0);
    // R6 new area, back to back
    run_access(2, 'h40, 0, 0, 0);
    // R7 read after read: no gap
    run_access(2, 'h44, 0, 0, 0);
    // R7 write after read: gap
    run_access(2, 'h48, 1, 0, 0);
    // R7 write after write, read after write: no gap
    run_access(2, 'h4c, 1, 0, 0);
    run_access(2, 'h50, 0, 0, 0);
    // R4 clamping
    run_access(3, 'h0, 0, 0, 0);
    run_access(4, 'h1, 1, 0, 0);
    run_access(5, 'h2, 0, 0, 0);
    run_access(6, 'h3, 1, 0, 0);
    // R5 ext_wait early ignored, then held
    run_access(6, 'h5, 1, 0, 1);
    run_access(3, 'h7, 0, 3, 1);
    run_access(2, 'h9, 1, 2, 0);
    // R2 bad areas and high bits; history unchanged
    run_bad(mk_addr(1, 'h10));
    run_bad(mk_addr(7, 'h10));
    run_bad(32'h2000_0000);
    run_access(2, 'hA, 1, 0, 0);
    // R8 width from a second strap value
    strap_w0 = 2'd1;
    run_access(0, 'h3ff_ffff, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule